// File: doc/BRIEF.md
# Cache-line burst memory responder

This block is the memory side of a 64-bit processor bus. On every address strobe it latches the starting quadword address, the cache-request flag, the read/write flag and eight byte-enables. It then decides whether the cycle is a single transfer or a four-beat cache-line burst. A burst read is granted only when the processor asks for a cacheable access and the starting quadword falls inside a configured cacheable window. The responder reports that decision on a cache-enable output during the first ready. A write that carries the cache-request flag is a line writeback and always runs as a burst. A plain write is a one-beat writethrough.

During a burst the responder steps through the line itself. It produces one ready strobe per beat and presents the quadword address of the current beat in interleaved order. Each beat reads or writes a small internal quadword array. Byte-enables shape single transfers only: a single read zeroes the lanes that are not enabled, and a single write updates only the enabled lanes. Bursts move all eight bytes of every beat.

Top module: `burst_mem_resp`

## Requirements
- R1: After reset `ready_o`, `ken_o` and `rdata_o` are all zero, and the responder is idle.
- R2: A read becomes a burst only when `cache_req_i` is high at the strobe and the starting quadword lies in the range CACHE_LO..CACHE_HI inclusive. `ken_o` is high only together with the first ready of such a burst read and is low for every other beat and cycle.
- R3: The ready strobes start in the clock cycle after the accepted strobe and come in consecutive cycles: exactly four for a burst and exactly one for a single transfer.
- R4: On beat b (0 to 3) of a burst, `beat_qaddr_o` equals the starting quadword address with its two low bits replaced by (start[1:0] XOR b). The upper bits stay those of the start, so every beat stays within the 32-byte line. A single transfer shows the starting address.
- R5: A burst read returns all eight bytes of each beat's quadword, whatever the byte-enables hold.
- R6: A single read returns byte lane i (`rdata_o` bits 8i+7..8i) only when `be_i[i]` was set at the strobe, and returns zero in that lane otherwise.
- R7: A write with `cache_req_i` high is a four-beat burst writeback, whatever the window. Each beat stores all eight bytes of `wdata_i` at that beat's address, and the byte-enables are ignored.
- R8: A write with `cache_req_i` low is a single transfer that updates only the byte lanes whose byte-enable is set. The other lanes keep their previous contents.
- R9: A strobe that arrives while a cycle is in progress is ignored and does not change the beat sequence. A new strobe is accepted at the first clock edge after the edge that ends the last ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ads_i | input | 1 | Address strobe, sampled when idle |
| cache_req_i | input | 1 | Processor requests a cacheable line access |
| write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| qaddr_i | input | QA_W | Starting quadword address (byte address bits 31..3) |
| be_i | input | 8 | Byte-enables, one per byte lane |
| wdata_i | input | 64 | Write data for the current beat |
| ready_o | output | 1 | One strobe per completed beat |
| ken_o | output | 1 | Burst read granted, valid with the first ready |
| beat_qaddr_o | output | QA_W | Quadword address of the current beat |
| rdata_o | output | 64 | Read data for the current beat |

## Verification
The assertions check on every cycle the properties that follow from the control state alone. Cache-enable appears only on the first ready of a read and only inside the window. A single transfer ends after one ready, and a burst keeps ready asserted until its last beat. Burst beats never leave the line and never repeat the previous quadword. The captured start never moves while busy. Data content cannot be checked this way: the interleaved beat order, the lane masking on single reads, byte-preserving partial writes and the loss of a stray strobe are shown only by the bench's sweeps. Those sweeps compare every beat's data and address against a memory model that the bench keeps itself.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int DATA_W = 64;
  localparam int LANES  = DATA_W / 8;
  localparam int BEATS  = 4;
  localparam int BEAT_W = $clog2(BEATS);
endpackage

// File: rtl/burst_decide.sv
module burst_decide #(
  parameter int               QA_W     = 29,
  parameter logic [QA_W-1:0]  CACHE_LO = 4,
  parameter logic [QA_W-1:0]  CACHE_HI = 19
) (
  input  logic [QA_W-1:0] qa_i,
  input  logic            cache_req_i,
  input  logic            write_i,
  output logic            burst_o
);
  logic in_win;
  assign in_win = (qa_i >= CACHE_LO) && (qa_i <= CACHE_HI);
  // writebacks are always line bursts; reads need the cacheable window
  assign burst_o = write_i ? cache_req_i : (cache_req_i && in_win);
endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq
  import burst_pkg::*;
#(
  parameter int QA_W = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              burst_i,
  input  logic [QA_W-1:0]   qa_i,
  output logic              busy_o,
  output logic              burst_o,
  output logic              first_o,
  output logic              last_o,
  output logic [QA_W-1:0]   qa_o
);
  logic              busy_q, burst_q;
  logic [BEAT_W-1:0] beat_q;
  logic [QA_W-1:0]   start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      burst_q <= 1'b0;
      beat_q  <= '0;
      start_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        burst_q <= burst_i;
        beat_q  <= '0;
        start_q <= qa_i;
      end
    end else begin
      if (last_o) busy_q <= 1'b0;
      beat_q <= beat_q + 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign burst_o = burst_q;
  assign first_o = (beat_q == '0);
  assign last_o  = busy_q && (!burst_q || (beat_q == BEAT_W'(BEATS - 1)));
  // interleaved order inside the line
  assign qa_o    = {start_q[QA_W-1:BEAT_W], start_q[BEAT_W-1:0] ^ beat_q};

  a_r3_single_one_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !burst_q) |-> first_o);
  a_r4_same_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !first_o) |-> (qa_o[QA_W-1:BEAT_W] == $past(qa_o[QA_W-1:BEAT_W])));
  a_r4_new_qword: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !first_o) |-> (qa_o[BEAT_W-1:0] != $past(qa_o[BEAT_W-1:0])));
  a_r9_start_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !first_o) |-> $stable(start_q));
endmodule

// File: rtl/qword_mem.sv
module qword_mem
  import burst_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LANES-1:0]  wmask_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      for (int b = 0; b < LANES; b++)
        if (wmask_i[b]) mem_q[idx_i][8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/burst_mem_resp.sv
module burst_mem_resp
  import burst_pkg::*;
#(
  parameter int               QA_W     = 29,
  parameter int               MEM_QW   = 32,
  parameter logic [QA_W-1:0]  CACHE_LO = 4,
  parameter logic [QA_W-1:0]  CACHE_HI = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ads_i,
  input  logic              cache_req_i,
  input  logic              write_i,
  input  logic [QA_W-1:0]   qaddr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              ken_o,
  output logic [QA_W-1:0]   beat_qaddr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = $clog2(MEM_QW);

  logic              burst_d, busy, burst, first, last, accept;
  logic              wr_q;
  logic [LANES-1:0]  be_q, lane_en;
  logic [QA_W-1:0]   cur_qa;
  logic [DATA_W-1:0] mem_rd, rmask;

  assign accept = ads_i && !busy;

  burst_decide #(.QA_W(QA_W), .CACHE_LO(CACHE_LO), .CACHE_HI(CACHE_HI)) u_decide (
    .qa_i        (qaddr_i),
    .cache_req_i (cache_req_i),
    .write_i     (write_i),
    .burst_o     (burst_d)
  );

  burst_beat_seq #(.QA_W(QA_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .burst_i (burst_d),
    .qa_i    (qaddr_i),
    .busy_o  (busy),
    .burst_o (burst),
    .first_o (first),
    .last_o  (last),
    .qa_o    (cur_qa)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b0;
      be_q <= '0;
    end else if (accept) begin
      wr_q <= write_i;
      be_q <= be_i;
    end
  end

  // bursts move whole quadwords; byte-enables shape single transfers only
  assign lane_en = burst ? '1 : be_q;

  qword_mem #(.DEPTH(MEM_QW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (busy && wr_q),
    .wmask_i (lane_en),
    .idx_i   (cur_qa[IDX_W-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (mem_rd)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rmask[8*g +: 8] = {8{lane_en[g]}};
  end

  assign ready_o      = busy;
  assign ken_o        = busy && first && burst && !wr_q;
  assign beat_qaddr_o = cur_qa;
  assign rdata_o      = (busy && !wr_q) ? (mem_rd & rmask) : '0;

  a_r2_ken_first_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ken_o |-> (ready_o && first && !wr_q));
  a_r2_ken_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ken_o |-> ((beat_qaddr_o >= CACHE_LO) && (beat_qaddr_o <= CACHE_HI)));
  a_r3_single_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !burst) |=> !ready_o);
  a_r3_burst_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && burst && !last) |=> ready_o);
  a_r9_idle_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && last) |=> !ready_o);
endmodule

// File: tb/sim_burst_mem_resp.sv
`timescale 1ns/1ps
module sim_burst_mem_resp;
  localparam int          QA_W = 29;
  localparam int          NQW  = 32;
  localparam logic [28:0] LO   = 29'd4;
  localparam logic [28:0] HI   = 29'd19;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ads = 1'b0, creq = 1'b0, wr = 1'b0;
  logic [QA_W-1:0] qa = '0;
  logic [7:0]  be = '0;
  logic [63:0] wd = '0;
  logic        rdy, ken;
  logic [QA_W-1:0] bqa;
  logic [63:0] rd;

  int checks = 0, errors = 0;
  logic [63:0] mdl [NQW];

  always #4 clk = ~clk;

  burst_mem_resp #(.QA_W(QA_W), .MEM_QW(NQW), .CACHE_LO(LO), .CACHE_HI(HI)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ads_i(ads), .cache_req_i(creq), .write_i(wr),
    .qaddr_i(qa), .be_i(be), .wdata_i(wd), .ready_o(rdy), .ken_o(ken),
    .beat_qaddr_o(bqa), .rdata_o(rd));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input logic [28:0] a, input logic [63:0] salt);
    return (64'h0102_0408_1020_4081 * (64'(a) + 64'd3)) ^ salt;
  endfunction

  // called at a negedge with the responder idle
  task automatic xfer(input logic [28:0] a, input logic c, input logic w,
                      input logic [7:0] e, input logic [63:0] salt, input logic stray);
    logic burst;
    int   nb;
    burst = w ? c : (c && a >= LO && a <= HI);
    nb = burst ? 4 : 1;
    chk("R9 idle before strobe", 64'(rdy), 64'd0);
    ads = 1'b1; creq = c; wr = w; qa = a; be = e;
    @(negedge clk);
    ads = 1'b0;
    for (int b = 0; b < nb; b++) begin
      logic [28:0] eqa;
      logic [63:0] exp, m;
      eqa = {a[28:2], a[1:0] ^ 2'(b)};
      chk("R3 ready per beat", 64'(rdy), 64'd1);
      chk("R2 ken", 64'(ken), 64'(b == 0 && burst && !w));
      chk("R4 beat address", 64'(bqa), 64'(eqa));
      m = '0;
      for (int l = 0; l < 8; l++) if (burst || e[l]) m[8*l +: 8] = 8'hFF;
      if (!w) begin
        exp = mdl[eqa[4:0]] & m;
        chk(burst ? "R5 burst read data" : "R6 single read lanes", rd, exp);
      end else begin
        wd = pat(eqa, salt);
        mdl[eqa[4:0]] = (mdl[eqa[4:0]] & ~m) | (wd & m);
      end
      if (stray && b == 1) begin
        ads = 1'b1; qa = a ^ 29'h1F; creq = ~c;
      end
      @(negedge clk);
      ads = 1'b0; qa = a; creq = c;
    end
    chk("R3 no extra ready", 64'(rdy), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NQW; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready reset", 64'(rdy), 64'd0);
    chk("R1 ken reset", 64'(ken), 64'd0);
    chk("R1 rdata reset", rd, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // fill via full single writes (R8)
    for (int q = 0; q < NQW; q++) xfer(29'(q), 1'b0, 1'b1, 8'hFF, 64'd0, 1'b0);
    // burst reads: granted only inside window (R2, R4, R5); stray strobes (R9)
    for (int q = 0; q < NQW; q++) xfer(29'(q), 1'b1, 1'b0, 8'h01, 64'd0, q % 5 == 1);
    // single reads with varied lane masks (R6)
    for (int q = 0; q < NQW; q++) xfer(29'(q), 1'b0, 1'b0, 8'(q * 29 + 3), 64'd0, 1'b0);
    // writebacks, inside and outside window, be ignored (R7)
    for (int l = 0; l < NQW / 4; l++)
      xfer(29'(l * 4 + (l % 4)), 1'b1, 1'b1, 8'h00, 64'h5A5A_0000_0000_0000 ^ 64'(l), l == 2);
    // partial writes over every mask (R8)
    for (int e = 0; e < 256; e++)
      xfer(29'(e % NQW), 1'b0, 1'b1, 8'(e), 64'hFFFF_0000_1234_5678 ^ 64'(e << 8), 1'b0);
    // read back everything
    for (int q = 0; q < NQW; q++) xfer(29'(q), 1'b1, 1'b0, 8'h00, 64'd0, 1'b0);
    for (int q = 0; q < NQW; q++) xfer(29'(q), 1'b0, 1'b0, 8'hFF, 64'd0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule